// File: doc/BRIEF.md
# Vector/Scalar Context Switch Controller

This controller sits beside one processing element of a multiprocessor array. The element keeps several process contexts resident at the same time, each in its own register-set slot. The controller decides which slot is live by rewriting a small pointer, so switching between processes needs no register save or restore.

A vector control unit can claim the element for a lockstep (SIMD) process and then broadcast instruction words to it. Each broadcast can arrive at any time. A flag records the arrival, and the controller acts on that flag only at the next instruction boundary. At that boundary it moves the pointer onto the vector slot and selects the broadcast as the fetch source. A scalar (MIMD) instruction already in progress therefore always runs to completion.

After each vector instruction the controller returns a one-cycle completion pulse, and the control unit waits for that pulse before it broadcasts again. A trap during vector execution raises a suspend request and moves the element onto a ready scalar context. The element stays allocated to the suspended vector process, and a later broadcast resumes it. A per-element mask makes the element ignore broadcasts while its scalar work keeps running. Slot 0 always holds the kernel.

Top module: `pe_ctx_switch`

## Requirements
- R1: While `rst` is high, and at the first sample after reset, the outputs take these values:
  - `mode_o` is 0 (idle);
  - `cpp_o`, `fetch_vec_o`, `done_o`, `suspend_o` and `overrun_o` are 0;
  - `vec_word_o` is 0.
- R2: The mode encoding is idle=0, kernel=1, vector=2, scalar=3. The idle and kernel modes change as follows:
  - From idle, an allocate or dispatch command to a nonzero slot moves the element to kernel.
  - A kernel with no resident scalar slot and no vector allocation returns to idle one cycle later.
- R3: In kernel or scalar mode, a dispatch to a nonzero slot that is not the vector slot has these effects on the next cycle:
  - `mode_o` becomes 3;
  - `cpp_o` becomes the dispatched slot;
  - the slot is marked resident.
- R4: A broadcast that arrives while the element is allocated and unmasked sets a pending flag but leaves `cpp_o` unchanged.
  - At the next `instr_end_i` in kernel or scalar mode, a set flag switches the element to `mode_o`=2, with `cpp_o` equal to the vector slot, `fetch_vec_o`=1 and `suspend_o`=0.
  - A broadcast that arrives in the same cycle as that `instr_end_i` is acted on only at a later boundary.
- R5: `done_o` is high for exactly one cycle, in the cycle after an `instr_end_i` that occurs in vector mode without a trap. `done_o` never rises in any other mode.
- R6: A trap in vector mode sets `suspend_o` and keeps the vector allocation.
  - If a ready scalar slot exists, the element moves to scalar mode and `cpp_o` points at the lowest-numbered ready slot.
  - If no scalar slot is ready, the element moves to kernel mode with `cpp_o`=0.
- R7: A trap in kernel or scalar mode moves the element to kernel mode with `cpp_o`=0.
- R8: While `mask_i` is high, broadcasts are ignored. `vec_word_o` does not change and no switch happens at `instr_end_i`, so the scalar context stays selected.
- R9: A deallocate command has these effects:
  - it clears the vector allocation, the pending flag, the overrun bit and the suspend request;
  - in vector mode it moves the element to kernel with `cpp_o`=0;
  - broadcasts that arrive afterwards are ignored.
- R10: Accepting a pending broadcast at an instruction boundary clears the pending flag. A second broadcast that arrives while the flag is still set raises `overrun_o`, which stays high until deallocate or reset.
- R11: `vec_word_o` holds the word of the most recently latched broadcast.
- R12: `exit_i` together with `instr_end_i` in scalar mode frees the current slot, moves the element to kernel and sets `cpp_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bcast_valid_i | input | 1 | Broadcast instruction strobe |
| bcast_word_i | input | WORD_W | Broadcast instruction word |
| mask_i | input | 1 | Element masked off from broadcasts |
| alloc_i | input | 1 | Allocate element to a vector process |
| alloc_slot_i | input | CPW | Slot that holds the vector context |
| dealloc_i | input | 1 | Release vector allocation |
| trap_i | input | 1 | Trap (for example a page fault) |
| instr_end_i | input | 1 | End of the current instruction cycle |
| dispatch_i | input | 1 | Kernel dispatch of a scalar process |
| dispatch_slot_i | input | CPW | Slot of the dispatched scalar context |
| exit_i | input | 1 | Current scalar process leaves (with instr_end_i) |
| mode_o | output | 2 | Mode: 0 idle, 1 kernel, 2 vector, 3 scalar |
| cpp_o | output | CPW | Current context pointer |
| fetch_vec_o | output | 1 | Fetch from broadcast (1) or local stream (0) |
| done_o | output | 1 | Vector instruction completion pulse |
| suspend_o | output | 1 | Request to halt broadcasting |
| overrun_o | output | 1 | Sticky second-broadcast overrun |
| vec_word_o | output | WORD_W | Latched broadcast word |

## Verification
The main sequence walks one element through every mode transition: arrival, scalar dispatches, allocation, resumption, vector completions, suspension, deallocation and exit. A separate case lands a broadcast in the same cycle as an instruction boundary; its switch must occur one boundary later, which checks that the flag is sampled only at the boundary. Back-to-back broadcasts with no boundary in between separate overrun from an ordinary refill. Directed cases cover three more situations:
- broadcasts while masked, where neither the pointer nor the word may change;
- a trap in vector mode with no ready scalar slot, which must fall back to slot 0;
- a reset in the middle of a run.

// File: rtl/pectx_pkg.sv
package pectx_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_KERNEL = 2'd1,
        MODE_VECTOR = 2'd2,
        MODE_SCALAR = 2'd3
    } pe_mode_e;

    typedef struct packed {
        logic alloc;
        logic dealloc;
        logic disp;
        logic trap;
        logic iend;
        logic exit_req;
    } pe_cmd_t;

    // Modes in which a pending broadcast may be taken at a boundary
    function automatic logic may_resume(pe_mode_e m);
        return (m == MODE_KERNEL) || (m == MODE_SCALAR);
    endfunction

endpackage

// File: rtl/ready_pick.sv
module ready_pick #(
    parameter int NCTX = 4,
    localparam int CPW = $clog2(NCTX)
) (
    input  logic [NCTX-1:0] cand_i,
    output logic            found_o,
    output logic [CPW-1:0]  idx_o
);
    // Lowest-numbered candidate above the kernel slot wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NCTX - 1; i >= 1; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                idx_o   = CPW'(i);
            end
        end
    end
endmodule

// File: rtl/bcast_latch.sv
module bcast_latch #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bv_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              enable_i,
    input  logic              consume_i,
    input  logic              clr_i,
    output logic              vip_o,
    output logic [WORD_W-1:0] word_o,
    output logic              overrun_o
);
    logic              vip_q;
    logic              ovr_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vip_q  <= 1'b0;
            ovr_q  <= 1'b0;
            word_q <= '0;
        end else if (clr_i) begin
            vip_q <= 1'b0;
            ovr_q <= 1'b0;
        end else if (bv_i && enable_i) begin
            word_q <= word_i;
            vip_q  <= 1'b1;
            if (vip_q && !consume_i) ovr_q <= 1'b1;
        end else if (consume_i) begin
            vip_q <= 1'b0;
        end
    end

    assign vip_o     = vip_q;
    assign word_o    = word_q;
    assign overrun_o = ovr_q;

    // R8: a disabled latch never picks up a broadcast
    assert_mask_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (!enable_i && !vip_q) |=> !vip_q);

    // R10: overrun stays set until cleared
    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !clr_i) |=> ovr_q);

endmodule

// File: rtl/ctx_fsm.sv
module ctx_fsm
    import pectx_pkg::*;
#(
    parameter int NCTX = 4,
    localparam int CPW = $clog2(NCTX)
) (
    input  logic            clk,
    input  logic            rst,
    input  pe_cmd_t         cmd_i,
    input  logic [CPW-1:0]  aslot_i,
    input  logic [CPW-1:0]  dslot_i,
    input  logic            mask_i,
    input  logic            vip_i,
    input  logic            ready_found_i,
    input  logic [CPW-1:0]  ready_idx_i,
    output pe_mode_e        mode_o,
    output logic [CPW-1:0]  cpp_o,
    output logic            simd_alloc_o,
    output logic [CPW-1:0]  simd_slot_o,
    output logic [NCTX-1:0] mimd_res_o,
    output logic            suspend_o,
    output logic            done_o,
    output logic            accept_o
);
    pe_mode_e        mode_q;
    logic [CPW-1:0]  cpp_q;
    logic            simd_alloc_q;
    logic [CPW-1:0]  simd_slot_q;
    logic [NCTX-1:0] mimd_res_q;
    logic            suspend_q;
    logic            done_q;

    logic accept, disp_ok, alloc_ok;

    always_comb begin
        accept   = cmd_i.iend && vip_i && simd_alloc_q && !cmd_i.trap && !cmd_i.dealloc
                   && ((mode_q == MODE_VECTOR) || (may_resume(mode_q) && !mask_i));
        disp_ok  = cmd_i.disp && (dslot_i != '0)
                   && !(simd_alloc_q && (dslot_i == simd_slot_q));
        alloc_ok = cmd_i.alloc && (aslot_i != '0) && (mode_q != MODE_VECTOR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= MODE_IDLE;
            cpp_q        <= '0;
            simd_alloc_q <= 1'b0;
            simd_slot_q  <= '0;
            mimd_res_q   <= '0;
            suspend_q    <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            done_q <= cmd_i.iend && (mode_q == MODE_VECTOR) && !cmd_i.trap;
            if (alloc_ok && !cmd_i.dealloc) begin
                simd_alloc_q <= 1'b1;
                simd_slot_q  <= aslot_i;
            end
            if (mode_q == MODE_IDLE) begin
                if (disp_ok) mimd_res_q[dslot_i] <= 1'b1;
                if (disp_ok || alloc_ok) mode_q <= MODE_KERNEL;
            end else if (cmd_i.trap) begin
                mode_q <= MODE_KERNEL;
                cpp_q  <= '0;
                if (mode_q == MODE_VECTOR) begin
                    suspend_q <= 1'b1;
                    if (ready_found_i) begin
                        mode_q <= MODE_SCALAR;
                        cpp_q  <= ready_idx_i;
                    end
                end
            end else if (cmd_i.dealloc) begin
                simd_alloc_q <= 1'b0;
                suspend_q    <= 1'b0;
                if (mode_q == MODE_VECTOR) begin
                    mode_q <= MODE_KERNEL;
                    cpp_q  <= '0;
                end
            end else if (accept) begin
                mode_q    <= MODE_VECTOR;
                cpp_q     <= simd_slot_q;
                suspend_q <= 1'b0;
            end else if ((mode_q == MODE_SCALAR) && cmd_i.iend && cmd_i.exit_req) begin
                mimd_res_q[cpp_q] <= 1'b0;
                mode_q            <= MODE_KERNEL;
                cpp_q             <= '0;
            end else if ((mode_q != MODE_VECTOR) && disp_ok) begin
                mimd_res_q[dslot_i] <= 1'b1;
                mode_q              <= MODE_SCALAR;
                cpp_q               <= dslot_i;
            end else if ((mode_q == MODE_KERNEL) && !alloc_ok
                         && (mimd_res_q == '0) && !simd_alloc_q) begin
                mode_q <= MODE_IDLE;
            end
        end
    end

    assign mode_o       = mode_q;
    assign cpp_o        = cpp_q;
    assign simd_alloc_o = simd_alloc_q;
    assign simd_slot_o  = simd_slot_q;
    assign mimd_res_o   = mimd_res_q;
    assign suspend_o    = suspend_q;
    assign done_o       = done_q;
    assign accept_o     = accept;

    // R4: in vector mode the pointer sits on the allocated vector slot
    assert_vector_ptr_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_VECTOR) |-> (simd_alloc_q && (cpp_q == simd_slot_q)));

    // R5: completion only follows a boundary in vector mode
    assert_done_source_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(cmd_i.iend) && ($past(mode_q) == MODE_VECTOR)));

    // R6: a trap during vector execution requests suspension
    assert_trap_vector_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.trap && (mode_q == MODE_VECTOR)) |=> suspend_q);

    // R7: a trap in scalar mode lands on the kernel slot
    assert_trap_scalar_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.trap && (mode_q == MODE_SCALAR)) |=> ((mode_q == MODE_KERNEL) && (cpp_q == '0)));

    // R9: deallocation drops the vector allocation
    assert_dealloc_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.dealloc && !cmd_i.trap && (mode_q != MODE_IDLE)) |=> !simd_alloc_q);

endmodule

// File: rtl/pe_ctx_switch.sv
module pe_ctx_switch
    import pectx_pkg::*;
#(
    parameter int NCTX   = 4,
    parameter int WORD_W = 32,
    localparam int CPW   = $clog2(NCTX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bcast_valid_i,
    input  logic [WORD_W-1:0] bcast_word_i,
    input  logic              mask_i,
    input  logic              alloc_i,
    input  logic [CPW-1:0]    alloc_slot_i,
    input  logic              dealloc_i,
    input  logic              trap_i,
    input  logic              instr_end_i,
    input  logic              dispatch_i,
    input  logic [CPW-1:0]    dispatch_slot_i,
    input  logic              exit_i,
    output logic [1:0]        mode_o,
    output logic [CPW-1:0]    cpp_o,
    output logic              fetch_vec_o,
    output logic              done_o,
    output logic              suspend_o,
    output logic              overrun_o,
    output logic [WORD_W-1:0] vec_word_o
);
    pe_cmd_t         cmd;
    pe_mode_e        mode;
    logic            simd_alloc, accept, vip, ready_found;
    logic [CPW-1:0]  simd_slot, ready_idx;
    logic [NCTX-1:0] mimd_res, simd_onehot, cand;

    always_comb begin
        cmd.alloc    = alloc_i;
        cmd.dealloc  = dealloc_i;
        cmd.disp     = dispatch_i;
        cmd.trap     = trap_i;
        cmd.iend     = instr_end_i;
        cmd.exit_req = exit_i;
        simd_onehot  = simd_alloc ? (NCTX'(1) << simd_slot) : '0;
        cand         = mimd_res & ~simd_onehot;
    end

    ready_pick #(.NCTX(NCTX)) u_pick (
        .cand_i  (cand),
        .found_o (ready_found),
        .idx_o   (ready_idx)
    );

    bcast_latch #(.WORD_W(WORD_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .bv_i      (bcast_valid_i),
        .word_i    (bcast_word_i),
        .enable_i  (simd_alloc && !mask_i),
        .consume_i (accept),
        .clr_i     (dealloc_i && (mode != MODE_IDLE)),
        .vip_o     (vip),
        .word_o    (vec_word_o),
        .overrun_o (overrun_o)
    );

    ctx_fsm #(.NCTX(NCTX)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cmd_i         (cmd),
        .aslot_i       (alloc_slot_i),
        .dslot_i       (dispatch_slot_i),
        .mask_i        (mask_i),
        .vip_i         (vip),
        .ready_found_i (ready_found),
        .ready_idx_i   (ready_idx),
        .mode_o        (mode),
        .cpp_o         (cpp_o),
        .simd_alloc_o  (simd_alloc),
        .simd_slot_o   (simd_slot),
        .mimd_res_o    (mimd_res),
        .suspend_o     (suspend_o),
        .done_o        (done_o),
        .accept_o      (accept)
    );

    assign mode_o      = mode;
    assign fetch_vec_o = (mode == MODE_VECTOR);

endmodule

// File: tb/tb_pe_ctx_switch.sv
module tb_pe_ctx_switch;

    typedef struct packed {
        logic       al;  logic [1:0] as;  logic dl;  logic dp;  logic [1:0] ds;
        logic       bv;  logic [7:0] w;   logic m;   logic t;   logic ie;  logic x;
        logic [7:0] exp;
    } vec_t;

    function automatic vec_t mk(int al, int as, int dl, int dp, int ds, int bv, int w,
                                int m, int t, int ie, int x,
                                int md, int cp, int fs, int dn, int su, int ov);
        vec_t v;
        v.al = 1'(al); v.as = 2'(as); v.dl = 1'(dl); v.dp = 1'(dp); v.ds = 2'(ds);
        v.bv = 1'(bv); v.w = 8'(w); v.m = 1'(m); v.t = 1'(t); v.ie = 1'(ie); v.x = 1'(x);
        v.exp = {2'(md), 2'(cp), 1'(fs), 1'(dn), 1'(su), 1'(ov)};
        return v;
    endfunction

    //                al as dl dp ds bv w     m  t  ie x   md cp fs dn su ov
    localparam vec_t TBL [24] = '{
        mk(0, 0, 0, 1, 1, 0, 0,    0, 0, 0, 0,  1, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 1, 1, 0, 0,    0, 0, 0, 0,  3, 1, 0, 0, 0, 0),
        mk(0, 0, 0, 1, 2, 0, 0,    0, 0, 0, 0,  3, 2, 0, 0, 0, 0),
        mk(1, 3, 0, 0, 0, 0, 0,    0, 0, 0, 0,  3, 2, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 1, 'hA1, 0, 0, 0, 0,  3, 2, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 0, 1, 0,  2, 3, 1, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 0, 1, 0,  2, 3, 1, 1, 0, 0),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 0, 0, 0,  2, 3, 1, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 1, 'hB2, 0, 0, 0, 0,  2, 3, 1, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 1, 'hC3, 0, 0, 0, 0,  2, 3, 1, 0, 0, 1),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 0, 1, 0,  2, 3, 1, 1, 0, 1),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 1, 0, 0,  3, 1, 0, 0, 1, 1),
        mk(0, 0, 0, 0, 0, 1, 'hD4, 0, 0, 1, 0,  3, 1, 0, 0, 1, 1),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 0, 1, 0,  2, 3, 1, 0, 0, 1),
        mk(0, 0, 1, 0, 0, 0, 0,    0, 0, 0, 0,  1, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 1, 'hE5, 0, 0, 0, 0,  1, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 0, 1, 0,  1, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 1, 2, 0, 0,    0, 0, 0, 0,  3, 2, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 1, 0, 0,  1, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 1, 1, 0, 0,    0, 0, 0, 0,  3, 1, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 0, 1, 1,  1, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 1, 2, 0, 0,    0, 0, 0, 0,  3, 2, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 0, 1, 1,  1, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 0, 0, 0,    0, 0, 0, 0,  0, 0, 0, 0, 0, 0)
    };

    function automatic string row_req(int i);
        case (i)
            0, 23:          return "R2";
            1, 2, 3, 17, 19, 21: return "R3";
            4, 5, 12, 13:   return "R4";
            6, 7, 10:       return "R5";
            8, 9:           return "R10";
            11:             return "R6";
            14, 15, 16:     return "R9";
            18:             return "R7";
            default:        return "R12";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst;
    logic        bcast_valid_i, mask_i, alloc_i, dealloc_i, trap_i;
    logic        instr_end_i, dispatch_i, exit_i;
    logic [31:0] bcast_word_i;
    logic [1:0]  alloc_slot_i, dispatch_slot_i;
    logic [1:0]  mode_o, cpp_o;
    logic        fetch_vec_o, done_o, suspend_o, overrun_o;
    logic [31:0] vec_word_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    pe_ctx_switch dut (
        .clk(clk), .rst(rst),
        .bcast_valid_i(bcast_valid_i), .bcast_word_i(bcast_word_i), .mask_i(mask_i),
        .alloc_i(alloc_i), .alloc_slot_i(alloc_slot_i), .dealloc_i(dealloc_i),
        .trap_i(trap_i), .instr_end_i(instr_end_i), .dispatch_i(dispatch_i),
        .dispatch_slot_i(dispatch_slot_i), .exit_i(exit_i),
        .mode_o(mode_o), .cpp_o(cpp_o), .fetch_vec_o(fetch_vec_o), .done_o(done_o),
        .suspend_o(suspend_o), .overrun_o(overrun_o), .vec_word_o(vec_word_o)
    );

    function automatic logic [7:0] obs();
        return {mode_o, cpp_o, fetch_vec_o, done_o, suspend_o, overrun_o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; return at the next falling edge
    task automatic apply(input vec_t v);
        alloc_i = v.al;  alloc_slot_i = v.as;  dealloc_i = v.dl;
        dispatch_i = v.dp;  dispatch_slot_i = v.ds;
        bcast_valid_i = v.bv;  bcast_word_i = {24'h0, v.w};
        mask_i = v.m;  trap_i = v.t;  instr_end_i = v.ie;  exit_i = v.x;
        @(negedge clk);
    endtask

    task automatic do_reset();
        apply(mk(0,0,0,0,0,0,0, 0,0,0,0, 0,0,0,0,0,0));
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1", {vec_word_o[23:0], obs()}, 32'h0);

        foreach (TBL[i]) begin
            apply(TBL[i]);
            chk(row_req(i), {24'h0, obs()}, {24'h0, TBL[i].exp});
        end

        // R8 and R11: masked broadcasts leave the word and the pointer untouched
        do_reset();
        apply(mk(1,2,0,0,0,0,0,    0,0,0,0, 1,0,0,0,0,0));
        apply(mk(0,0,0,1,1,0,0,    0,0,0,0, 3,1,0,0,0,0));
        apply(mk(0,0,0,0,0,1,'h55, 1,0,0,0, 3,1,0,0,0,0));
        chk("R8", vec_word_o, 32'h0);
        apply(mk(0,0,0,0,0,0,0,    1,0,1,0, 3,1,0,0,0,0));
        chk("R8", {24'h0, obs()}, {24'h0, 2'd3, 2'd1, 4'b0000});
        apply(mk(0,0,0,0,0,1,'h66, 0,0,0,0, 3,1,0,0,0,0));
        chk("R11", vec_word_o, 32'h66);
        apply(mk(0,0,0,0,0,0,0,    0,0,1,0, 2,2,1,0,0,0));
        chk("R4", {24'h0, obs()}, {24'h0, 2'd2, 2'd2, 4'b1000});

        // R6: trap in vector mode with no ready scalar slot falls back to slot 0
        do_reset();
        apply(mk(1,3,0,0,0,0,0,    0,0,0,0, 1,0,0,0,0,0));
        apply(mk(0,0,0,0,0,1,'h77, 0,0,0,0, 1,0,0,0,0,0));
        apply(mk(0,0,0,0,0,0,0,    0,0,1,0, 2,3,1,0,0,0));
        chk("R4", {24'h0, obs()}, {24'h0, 2'd2, 2'd3, 4'b1000});
        apply(mk(0,0,0,0,0,0,0,    0,1,0,0, 1,0,0,0,1,0));
        chk("R6", {24'h0, obs()}, {24'h0, 2'd1, 2'd0, 4'b0010});
        apply(mk(0,0,0,0,0,1,'h88, 0,0,0,0, 1,0,0,0,1,0));
        apply(mk(0,0,0,0,0,0,0,    0,0,1,0, 2,3,1,0,0,0));
        chk("R6", {24'h0, obs()}, {24'h0, 2'd2, 2'd3, 4'b1000});
        chk("R11", vec_word_o, 32'h88);

        // R1: reset in the middle of a vector run
        do_reset();
        chk("R1", {vec_word_o[23:0], obs()}, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule